// File: doc/BRIEF.md
# PHY Analog Trim Loading Sequencer

This block runs once after an internal PHY leaves reset. A start pulse hands it a 32-bit fused trim word and a PHY address. It then loads three analog calibration fields into the PHY through an external MDIO master. The PHY's extended register space has no direct path, so every access is an indirect pair. The pair is a write of the extended address to management register 0x1E, then a read or write of the data at management register 0x1D. Each field is merged into its target by read-modify-write, and only the field's low bits change. The PHY is then told that configuration is finished, and the block waits, with bounded polling, for the PHY to acknowledge.

When all three fields are zero, there is nothing to load. The block then writes nothing and instead polls the PHY's own auto-trim completion bit a small number of times. Both paths end with a settle wait before done is raised. Poll spacing, poll limits and the settle time are parameters counted in clock cycles.

Top module: `phy_trim_loader`

## Requirements
- R1: After reset, done_o, timeout_o, ack_early_o and mreq_valid_o are all 0, and no request is issued until start_i is seen.
- R2: Every request carries the PHY address sampled with start_i. Later changes on phy_addr_i and trim_word_i have no effect on the run.
- R3: Each extended access is a write of the extended address to register 0x1E, followed by exactly one read or write at register 0x1D. No other register number is used.
- R4: Field A is trim bits [29:25] into extended 0x3050 bits [4:0]. Field B is bits [24:22] into 0x3051 bits [2:0]. Field C is bits [21:16] into 0x3052 bits [5:0]. The upper bits of each register keep the value that was read.
- R5: On the load path, the extended writes occur in the order 0x3050, 0x3051, 0x3052, 0x3053. The write to 0x3053 is the value read from it with bit 0 set.
- R6: ack_early_o is set when bit 1 of 0x3053 is already 1 in the read that comes before the bit-0 write. It is otherwise 0.
- R7: After the bit-0 write, 0x3053 is polled until bit 1 reads 1, with at most ACK_POLLS reads. Reads are at least ACK_GAP cycles apart. timeout_o is set when the last permitted read still shows bit 1 as 0.
- R8: When trim bits [29:16] are all zero, no extended write occurs. Instead 0x3057 is read until bit 0 reads 1, with at most AUTO_POLLS reads at least AUTO_GAP cycles apart. timeout_o is set if bit 0 never reads 1.
- R9: done_o rises no sooner than SETTLE cycles after the last MDIO response, with no request pending. It then stays high until the next start. A start_i that arrives while a run is in progress is ignored.
- R10: A request keeps mreq_valid_o and all its fields stable until the cycle in which mrsp_valid_i is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse that begins a run |
| phy_addr_i | input | 5 | PHY address, sampled at start |
| trim_word_i | input | 32 | Fused trim word, sampled at start |
| mreq_valid_o | output | 1 | MDIO request pending |
| mreq_write_o | output | 1 | 1 = write, 0 = read |
| mreq_phy_o | output | 5 | PHY address of the request |
| mreq_reg_o | output | 5 | Management register number |
| mreq_wdata_o | output | 16 | Write data |
| mrsp_valid_i | input | 1 | One-cycle completion of the pending request |
| mrsp_rdata_i | input | 16 | Read data, valid with mrsp_valid_i |
| done_o | output | 1 | Run finished, held until next start |
| timeout_o | output | 1 | Poll limit reached without the awaited bit |
| ack_early_o | output | 1 | Acknowledge bit was already set before config done |

## Verification
A stuck or misordered sequencer state shows up at the PHY model's register file after a single run. It appears as a wrong trim value, an upper bit that was lost, or a write order other than the four-step sequence. A wrong poll count shows up as the number of reads the model served and as the level of timeout_o once done_o rises. A timer or settle fault shows as poll reads closer together than the configured gap, or as done_o arriving too soon after the last response. All of these are visible within the run that caused them.

// File: rtl/trim_seq_pkg.sv
package trim_seq_pkg;

   localparam int NFLD = 3;

   localparam logic [4:0]  MII_XADDR = 5'h1E;
   localparam logic [4:0]  MII_XDATA = 5'h1D;
   localparam logic [15:0] XREG_TRIM0 = 16'h3050;
   localparam logic [15:0] XREG_CFG   = 16'h3053;
   localparam logic [15:0] XREG_AUTO  = 16'h3057;

   function automatic int fld_lsb(input int i);
      case (i)
         0:       return 25;
         1:       return 22;
         default: return 16;
      endcase
   endfunction

   function automatic int fld_w(input int i);
      case (i)
         0:       return 5;
         1:       return 3;
         default: return 6;
      endcase
   endfunction

   typedef enum logic [3:0] {
      S_IDLE,
      S_FRD,
      S_FWR,
      S_CRD,
      S_CWR,
      S_AWAIT,
      S_ARD,
      S_ZWAIT,
      S_ZRD,
      S_SETTLE
   } seq_state_t;

endpackage

// File: rtl/trim_merge.sv
module trim_merge
   import trim_seq_pkg::*;
(
   input  logic [31:0] trim_i,
   input  logic [1:0]  sel_i,
   input  logic [15:0] rd_i,
   output logic [15:0] merged_o,
   output logic        none_o
);

   logic [15:0]     cand [NFLD];
   logic [NFLD-1:0] nz;

   for (genvar g = 0; g < NFLD; g++) begin : g_fld
      localparam int L = fld_lsb(g);
      localparam int W = fld_w(g);
      if (W < 1 || W > 15 || L + W > 32) begin : g_bad
         $error("trim field %0d does not fit", g);
      end
      assign cand[g] = {rd_i[15:W], trim_i[L+W-1:L]};
      assign nz[g]   = |trim_i[L+W-1:L];
   end

   always_comb begin
      merged_o = cand[0];
      for (int i = 1; i < NFLD; i++) begin
         if (sel_i == 2'(i)) merged_o = cand[i];
      end
   end

   assign none_o = ~|nz;

endmodule

// File: rtl/exp_access.sv
module exp_access
   import trim_seq_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        go_i,
   input  logic        wr_i,
   input  logic [15:0] xaddr_i,
   input  logic [15:0] wdata_i,
   output logic        fin_o,
   output logic [15:0] rdata_o,
   output logic        req_valid_o,
   output logic        req_write_o,
   output logic [4:0]  req_reg_o,
   output logic [15:0] req_wdata_o,
   input  logic        rsp_valid_i,
   input  logic [15:0] rsp_rdata_i
);

   typedef enum logic [1:0] {E_IDLE, E_ADR, E_DAT} eng_t;

   eng_t        st_q;
   logic        wr_q;
   logic [15:0] addr_q, wdata_q, rdata_q;
   logic        fin_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= E_IDLE;
         wr_q    <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
         fin_q   <= 1'b0;
      end else begin
         fin_q <= 1'b0;
         case (st_q)
            E_IDLE: if (go_i) begin
               wr_q    <= wr_i;
               addr_q  <= xaddr_i;
               wdata_q <= wdata_i;
               st_q    <= E_ADR;
            end
            E_ADR: if (rsp_valid_i) st_q <= E_DAT;
            E_DAT: if (rsp_valid_i) begin
               rdata_q <= rsp_rdata_i;
               fin_q   <= 1'b1;
               st_q    <= E_IDLE;
            end
            default: st_q <= E_IDLE;
         endcase
      end
   end

   assign req_valid_o = (st_q != E_IDLE);
   assign req_write_o = (st_q == E_ADR) ? 1'b1 : wr_q;
   assign req_reg_o   = (st_q == E_ADR) ? MII_XADDR : MII_XDATA;
   assign req_wdata_o = (st_q == E_ADR) ? addr_q : wdata_q;
   assign fin_o       = fin_q;
   assign rdata_o     = rdata_q;

   // R10
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_o && !rsp_valid_i) |=> (req_valid_o && $stable(req_reg_o)
         && $stable(req_write_o) && $stable(req_wdata_o)));

   // R3
   addr_then_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_o && req_reg_o == MII_XADDR && rsp_valid_i)
         |=> (req_valid_o && req_reg_o == MII_XDATA));

endmodule

// File: rtl/cyc_timer.sv
module cyc_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go_i,
   input  logic [W-1:0] len_i,
   output logic         fin_o
);

   logic [W-1:0] cnt_q;
   logic         run_q;
   logic         fin_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= 1'b0;
         fin_q <= 1'b0;
      end else begin
         fin_q <= 1'b0;
         if (go_i) begin
            cnt_q <= len_i;
            run_q <= 1'b1;
         end else if (run_q) begin
            if (cnt_q <= W'(1)) begin
               fin_q <= 1'b1;
               run_q <= 1'b0;
            end else begin
               cnt_q <= cnt_q - W'(1);
            end
         end
      end
   end

   assign fin_o = fin_q;

   // R9
   timer_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go_i |-> !run_q);

endmodule

// File: rtl/phy_trim_loader.sv
module phy_trim_loader
   import trim_seq_pkg::*;
#(
   parameter int ACK_POLLS  = 3000,
   parameter int ACK_GAP    = 10000,
   parameter int AUTO_POLLS = 3,
   parameter int AUTO_GAP   = 25000000,
   parameter int SETTLE     = 500000
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start_i,
   input  logic [4:0]  phy_addr_i,
   input  logic [31:0] trim_word_i,
   output logic        mreq_valid_o,
   output logic        mreq_write_o,
   output logic [4:0]  mreq_phy_o,
   output logic [4:0]  mreq_reg_o,
   output logic [15:0] mreq_wdata_o,
   input  logic        mrsp_valid_i,
   input  logic [15:0] mrsp_rdata_i,
   output logic        done_o,
   output logic        timeout_o,
   output logic        ack_early_o
);

   localparam int G1   = (ACK_GAP > AUTO_GAP) ? ACK_GAP : AUTO_GAP;
   localparam int GMAX = (G1 > SETTLE) ? G1 : SETTLE;
   localparam int TW   = $clog2(GMAX + 1);
   localparam int PMAX = (ACK_POLLS > AUTO_POLLS) ? ACK_POLLS : AUTO_POLLS;
   localparam int PW   = $clog2(PMAX + 1);

   if (ACK_POLLS < 1 || AUTO_POLLS < 1) begin : g_bad_polls
      $error("poll limits must be at least 1");
   end
   if (ACK_GAP < 1 || AUTO_GAP < 1 || SETTLE < 1) begin : g_bad_waits
      $error("wait lengths must be at least 1");
   end

   seq_state_t  state_q;
   logic [4:0]  phy_q;
   logic [31:0] trim_q;
   logic [1:0]  fidx_q;
   logic [PW-1:0] pcnt_q;
   logic        acc_go_q, acc_wr_q;
   logic [15:0] acc_addr_q, acc_wdata_q;
   logic        tmr_go_q;
   logic [TW-1:0] tmr_len_q;
   logic        done_q, tout_q, early_q, zpath_q;

   logic        acc_fin;
   logic [15:0] acc_rdata;
   logic [15:0] merged;
   logic        none_w;
   logic        tmr_fin;
   logic [31:0] trim_sel;

   assign trim_sel = (state_q == S_IDLE) ? trim_word_i : trim_q;

   trim_merge u_merge (
      .trim_i   (trim_sel),
      .sel_i    (fidx_q),
      .rd_i     (acc_rdata),
      .merged_o (merged),
      .none_o   (none_w)
   );

   exp_access u_access (
      .clk         (clk),
      .rst_n       (rst_n),
      .go_i        (acc_go_q),
      .wr_i        (acc_wr_q),
      .xaddr_i     (acc_addr_q),
      .wdata_i     (acc_wdata_q),
      .fin_o       (acc_fin),
      .rdata_o     (acc_rdata),
      .req_valid_o (mreq_valid_o),
      .req_write_o (mreq_write_o),
      .req_reg_o   (mreq_reg_o),
      .req_wdata_o (mreq_wdata_o),
      .rsp_valid_i (mrsp_valid_i),
      .rsp_rdata_i (mrsp_rdata_i)
   );

   cyc_timer #(.W(TW)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .go_i  (tmr_go_q),
      .len_i (tmr_len_q),
      .fin_o (tmr_fin)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= S_IDLE;
         phy_q       <= '0;
         trim_q      <= '0;
         fidx_q      <= '0;
         pcnt_q      <= '0;
         acc_go_q    <= 1'b0;
         acc_wr_q    <= 1'b0;
         acc_addr_q  <= '0;
         acc_wdata_q <= '0;
         tmr_go_q    <= 1'b0;
         tmr_len_q   <= '0;
         done_q      <= 1'b0;
         tout_q      <= 1'b0;
         early_q     <= 1'b0;
         zpath_q     <= 1'b0;
      end else begin
         acc_go_q <= 1'b0;
         tmr_go_q <= 1'b0;
         case (state_q)
            S_IDLE: if (start_i) begin
               phy_q   <= phy_addr_i;
               trim_q  <= trim_word_i;
               done_q  <= 1'b0;
               tout_q  <= 1'b0;
               early_q <= 1'b0;
               pcnt_q  <= '0;
               fidx_q  <= '0;
               zpath_q <= none_w;
               if (none_w) begin
                  tmr_go_q  <= 1'b1;
                  tmr_len_q <= TW'(AUTO_GAP);
                  state_q   <= S_ZWAIT;
               end else begin
                  acc_go_q   <= 1'b1;
                  acc_wr_q   <= 1'b0;
                  acc_addr_q <= XREG_TRIM0;
                  state_q    <= S_FRD;
               end
            end
            S_FRD: if (acc_fin) begin
               acc_go_q    <= 1'b1;
               acc_wr_q    <= 1'b1;
               acc_wdata_q <= merged;
               state_q     <= S_FWR;
            end
            S_FWR: if (acc_fin) begin
               acc_go_q <= 1'b1;
               acc_wr_q <= 1'b0;
               if (fidx_q == 2'(NFLD - 1)) begin
                  acc_addr_q <= XREG_CFG;
                  state_q    <= S_CRD;
               end else begin
                  fidx_q     <= fidx_q + 2'd1;
                  acc_addr_q <= XREG_TRIM0 + {14'd0, fidx_q} + 16'd1;
                  state_q    <= S_FRD;
               end
            end
            S_CRD: if (acc_fin) begin
               early_q     <= acc_rdata[1];
               acc_go_q    <= 1'b1;
               acc_wr_q    <= 1'b1;
               acc_wdata_q <= acc_rdata | 16'h0001;
               state_q     <= S_CWR;
            end
            S_CWR: if (acc_fin) begin
               tmr_go_q  <= 1'b1;
               tmr_len_q <= TW'(ACK_GAP);
               state_q   <= S_AWAIT;
            end
            S_AWAIT, S_ZWAIT: if (tmr_fin) begin
               acc_go_q   <= 1'b1;
               acc_wr_q   <= 1'b0;
               acc_addr_q <= (state_q == S_AWAIT) ? XREG_CFG : XREG_AUTO;
               pcnt_q     <= pcnt_q + PW'(1);
               state_q    <= (state_q == S_AWAIT) ? S_ARD : S_ZRD;
            end
            S_ARD, S_ZRD: if (acc_fin) begin
               tmr_go_q <= 1'b1;
               if ((state_q == S_ARD) ? acc_rdata[1] : acc_rdata[0]) begin
                  tmr_len_q <= TW'(SETTLE);
                  state_q   <= S_SETTLE;
               end else if (pcnt_q == ((state_q == S_ARD) ? PW'(ACK_POLLS)
                                                          : PW'(AUTO_POLLS))) begin
                  tout_q    <= 1'b1;
                  tmr_len_q <= TW'(SETTLE);
                  state_q   <= S_SETTLE;
               end else begin
                  tmr_len_q <= (state_q == S_ARD) ? TW'(ACK_GAP) : TW'(AUTO_GAP);
                  state_q   <= (state_q == S_ARD) ? S_AWAIT : S_ZWAIT;
               end
            end
            S_SETTLE: if (tmr_fin) begin
               done_q  <= 1'b1;
               state_q <= S_IDLE;
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign mreq_phy_o  = phy_q;
   assign done_o      = done_q;
   assign timeout_o   = tout_q;
   assign ack_early_o = early_q;

   // R9
   done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !mreq_valid_o);

   // R8
   auto_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(zpath_q && state_q != S_IDLE && mreq_valid_o && mreq_write_o
        && mreq_reg_o == MII_XDATA));

   // R7
   ack_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_AWAIT) |-> (pcnt_q < PW'(ACK_POLLS)));

   // R6
   early_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_early_o) |-> ($past(state_q) == S_CRD));

endmodule

// File: tb/test_phy_trim_loader.sv
module test_phy_trim_loader;

   localparam int CLK_PERIOD = 10;
   localparam int ACK_POLLS  = 4;
   localparam int ACK_GAP    = 6;
   localparam int AUTO_POLLS = 3;
   localparam int AUTO_GAP   = 8;
   localparam int SETTLE     = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [4:0]  phy_addr_i = '0;
   logic [31:0] trim_word_i = '0;
   logic        mreq_valid_o, mreq_write_o;
   logic [4:0]  mreq_phy_o, mreq_reg_o;
   logic [15:0] mreq_wdata_o;
   logic        mrsp_valid_i = 1'b0;
   logic [15:0] mrsp_rdata_i = '0;
   logic        done_o, timeout_o, ack_early_o;

   always #(CLK_PERIOD / 2) clk = ~clk;

   phy_trim_loader #(
      .ACK_POLLS(ACK_POLLS), .ACK_GAP(ACK_GAP), .AUTO_POLLS(AUTO_POLLS),
      .AUTO_GAP(AUTO_GAP), .SETTLE(SETTLE)
   ) i_phy_trim_loader (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .phy_addr_i(phy_addr_i),
      .trim_word_i(trim_word_i), .mreq_valid_o(mreq_valid_o),
      .mreq_write_o(mreq_write_o), .mreq_phy_o(mreq_phy_o),
      .mreq_reg_o(mreq_reg_o), .mreq_wdata_o(mreq_wdata_o),
      .mrsp_valid_i(mrsp_valid_i), .mrsp_rdata_i(mrsp_rdata_i),
      .done_o(done_o), .timeout_o(timeout_o), .ack_early_o(ack_early_o)
   );

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   always @(posedge clk) cyc <= cyc + 1;

   // PHY model state
   logic [15:0] mem [8];
   logic [15:0] xptr;
   logic [15:0] wr_log [16];
   int   wr_n, cfg_rd, at_rd, ack_after, at_after;
   bit   done_flag, fresh;
   int   phy_bad, bad3, unstable;
   int   last_poll, min_gap, last_rsp;
   logic [4:0] exp_phy;
   logic [1:0] lat = '0;
   logic       p_wr;
   logic [4:0] p_reg;
   logic [15:0] p_wd;

   always @(posedge clk) begin
      mrsp_valid_i <= 1'b0;
      if (mreq_valid_o && !mrsp_valid_i) begin
         if (lat != 0 && (p_wr != mreq_write_o || p_reg != mreq_reg_o || p_wd != mreq_wdata_o))
            unstable++;
         p_wr = mreq_write_o; p_reg = mreq_reg_o; p_wd = mreq_wdata_o;
         if (lat == 2'd1) begin
            logic [15:0] v;
            int idx;
            lat <= '0;
            v = 16'h0000;
            if (mreq_phy_o != exp_phy) phy_bad++;
            if (mreq_reg_o == 5'h1E && mreq_write_o) begin
               xptr = mreq_wdata_o;
               fresh = 1'b1;
            end else if (mreq_reg_o == 5'h1D) begin
               if (!fresh) bad3++;
               fresh = 1'b0;
               idx = int'(xptr) - 32'h3050;
               if (idx >= 0 && idx < 8) begin
                  if (mreq_write_o) begin
                     mem[idx] = mreq_wdata_o;
                     if (wr_n < 16) wr_log[wr_n] = xptr;
                     wr_n++;
                     if (idx == 3 && mreq_wdata_o[0]) done_flag = 1'b1;
                  end else begin
                     v = mem[idx];
                     if (idx == 3 && done_flag) begin
                        cfg_rd++;
                        if (cfg_rd >= ack_after) v[1] = 1'b1;
                        if (last_poll >= 0 && cyc - last_poll < min_gap) min_gap = cyc - last_poll;
                        last_poll = cyc;
                     end
                     if (idx == 7) begin
                        at_rd++;
                        if (at_rd >= at_after) v[0] = 1'b1;
                        if (last_poll >= 0 && cyc - last_poll < min_gap) min_gap = cyc - last_poll;
                        last_poll = cyc;
                     end
                  end
               end else bad3++;
            end else bad3++;
            mrsp_rdata_i <= v;
            mrsp_valid_i <= 1'b1;
            last_rsp = cyc;
         end else lat <= lat + 2'd1;
      end
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
      end
   endtask

   task automatic run(input logic [31:0] tw, input logic [4:0] pa, input int aa,
                      input int ta, input bit preset, input logic [15:0] ib,
                      input bit restart);
      logic [4:0] f0, f1, f2;
      logic [15:0] i0, i1, i2, i3;
      bit zero, got;
      int polls, done_cyc;
      bit exp_to;
      for (int k = 0; k < 8; k++) mem[k] = ib ^ (16'(k) * 16'h1111);
      mem[3][1:0] = {preset, 1'b0};
      mem[7][0] = 1'b0;
      i0 = mem[0]; i1 = mem[1]; i2 = mem[2]; i3 = mem[3];
      wr_n = 0; cfg_rd = 0; at_rd = 0; done_flag = 0; fresh = 0;
      phy_bad = 0; bad3 = 0; unstable = 0; last_poll = -1; min_gap = 1000000;
      ack_after = aa; at_after = ta; exp_phy = pa;
      f0 = 5'(tw[29:25]); f1 = 5'(tw[24:22]); f2 = 5'(tw[21:16] & 6'h1F);
      zero = (tw[29:16] == 14'd0);
      @(negedge clk);
      phy_addr_i = pa; trim_word_i = tw; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0; phy_addr_i = ~pa; trim_word_i = ~tw;
      if (restart) begin
         repeat (15) @(negedge clk);
         start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
      end
      got = 0; done_cyc = 0;
      for (int t = 0; t < 5000 && !got; t++) begin
         @(negedge clk);
         if (done_o) begin got = 1; done_cyc = cyc; end
      end
      chk(got, "R9", "done reached", int'(got), 1);
      chk(phy_bad == 0, "R2", "requests with wrong phy", phy_bad, 0);
      chk(bad3 == 0, "R3", "bad indirect accesses", bad3, 0);
      chk(unstable == 0, "R10", "request changed while pending", unstable, 0);
      chk(done_cyc - last_rsp >= SETTLE, "R9", "settle cycles", done_cyc - last_rsp, SETTLE);
      if (!zero) begin
         polls  = preset ? 1 : ((aa < ACK_POLLS) ? aa : ACK_POLLS);
         exp_to = !preset && aa > ACK_POLLS;
         chk(mem[0] == ((i0 & 16'hFFE0) | {11'd0, f0}), "R4", "reg 3050", int'(mem[0]),
             int'((i0 & 16'hFFE0) | {11'd0, f0}));
         chk(mem[1] == ((i1 & 16'hFFF8) | {13'd0, tw[24:22]}), "R4", "reg 3051", int'(mem[1]),
             int'((i1 & 16'hFFF8) | {13'd0, tw[24:22]}));
         chk(mem[2] == ((i2 & 16'hFFC0) | {10'd0, tw[21:16]}), "R4", "reg 3052", int'(mem[2]),
             int'((i2 & 16'hFFC0) | {10'd0, tw[21:16]}));
         chk(mem[3] == (i3 | 16'h0001), "R5", "reg 3053", int'(mem[3]), int'(i3 | 16'h0001));
         chk(wr_n == 4, "R5", "write count", wr_n, 4);
         for (int k = 0; k < 4; k++)
            chk(wr_log[k] == 16'h3050 + 16'(k), "R5", "write order", int'(wr_log[k]),
                32'h3050 + k);
         chk(ack_early_o == preset, "R6", "early ack flag", int'(ack_early_o), int'(preset));
         chk(cfg_rd == polls, "R7", "ack polls", cfg_rd, polls);
         chk(timeout_o == exp_to, "R7", "ack timeout", int'(timeout_o), int'(exp_to));
         if (polls > 1) chk(min_gap >= ACK_GAP, "R7", "ack poll gap", min_gap, ACK_GAP);
      end else begin
         polls  = (ta < AUTO_POLLS) ? ta : AUTO_POLLS;
         exp_to = ta > AUTO_POLLS;
         chk(wr_n == 0, "R8", "writes on auto path", wr_n, 0);
         chk(at_rd == polls, "R8", "auto polls", at_rd, polls);
         chk(timeout_o == exp_to, "R8", "auto timeout", int'(timeout_o), int'(exp_to));
         chk(ack_early_o == 1'b0, "R6", "early flag on auto path", int'(ack_early_o), 0);
         if (polls > 1) chk(min_gap >= AUTO_GAP, "R8", "auto poll gap", min_gap, AUTO_GAP);
      end
      repeat (3) @(negedge clk);
      chk(done_o == 1'b1, "R9", "done held", int'(done_o), 1);
      chk(mreq_valid_o == 1'b0, "R9", "idle after done", int'(mreq_valid_o), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!done_o && !timeout_o && !ack_early_o, "R1", "flags in reset",
          int'({done_o, timeout_o, ack_early_o}), 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(mreq_valid_o == 1'b0, "R1", "no request before start", int'(mreq_valid_o), 0);
      chk(done_o == 1'b0, "R1", "done low before start", int'(done_o), 0);
      // walk one bit through every trim field position
      for (int b = 16; b < 30; b++)
         run(32'(1) << b, 5'(b), 2, 1, 0, 16'hA5C3 ^ 16'(b * 313), 0);
      run(32'hFFFF_FFFF, 5'd31, 1, 1, 0, 16'h0000, 0);
      run(32'hC000_FFFF | (32'h2AAA << 16), 5'd0, 1, 1, 0, 16'hFFFF, 0);
      // ack arriving at every poll position, and never
      for (int a = 1; a <= ACK_POLLS + 1; a++)
         run(32'h1234_5678, 5'd9, a, 1, 0, 16'h5A5A, 0);
      run(32'h0ABC_0000, 5'd17, 3, 1, 1, 16'h3C3C, 0);
      // zero fields: auto-trim path with completion at every position, and never
      for (int a = 1; a <= AUTO_POLLS + 1; a++)
         run(32'hC000_FFFF, 5'd4, 1, a, 0, 16'h9999, 0);
      run(32'h3FFF_0000, 5'd21, 2, 1, 0, 16'h7E81, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule